// File: doc/BRIEF.md
# Key-Sequence Watchdog Reset Timer

This block is a watchdog that requests a system reset when software stops servicing it. To service it, software writes the arm key `0x55` to the service register and later writes the fire key `0xAA`. Any number of unrelated bus cycles, including writes of other values, may fall between the two keys. Servicing clears the timeout counter.

The bus clock feeds a free-running prescaler of 2^`PRESC_W` cycles, which produces one base tick per period. A 2-bit rate select sets the timeout to 1, 4, 16 or 64 base ticks. The prescaler phase is not reset when the watchdog is serviced. Because of this, the real timeout is never shorter than nominal and is at most one base-tick period longer.

When the timeout expires, the active-low reset request is driven low for a fixed four bus clocks. That pulse also clears the watchdog's own prescaler, counter and key state. A configuration enable input, held by storage outside the block, switches the whole function on or off.

Top module: `key_wdt`

## Requirements
- R1: Writing `0x55` and then `0xAA` to the service register clears the timeout counter, and the fire key also disarms the sequence. Repeating this sequence more often than the timeout keeps `sys_rst_no` high.
- R2: Once the arm key has been written, idle cycles and writes of values other than `0xAA` leave the sequence armed. The next `0xAA` still services the watchdog.
- R3: A write of `0xAA` while the sequence is not armed has no effect. The timeout still expires as measured from the last valid service.
- R4: With P = 2^`PRESC_W` and N = 1, 4, 16 or 64 for rate select 00, 01, 10 or 11, `sys_rst_no` goes low between N*P+1 and (N+1)*P clocks after the clock edge that takes the servicing `0xAA` write.
- R5: Each reset request holds `sys_rst_no` low for exactly 4 clocks and then releases it.
- R6: While `wdt_en_i` is 0, `sys_rst_no` stays high, and the prescaler, counter and key state are held cleared.
- R7: During power-on reset `sys_rst_no` is high. After `rst_ni` is released, the first timeout follows the R4 window, measured from release.
- R8: After a reset pulse ends, the prescaler and counter restart from zero. The next request follows (N+1)*P clocks after `sys_rst_no` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| wr_en_i | input | 1 | Write strobe for the service register |
| wr_data_i | input | 8 | Data written to the service register |
| wdt_en_i | input | 1 | Watchdog enable from configuration storage |
| rate_sel_i | input | 2 | Timeout select: 1, 4, 16 or 64 base ticks |
| sys_rst_no | output | 1 | System reset request, active low |

## Verification
The bench builds the block with `PRESC_W` = 3, so one base tick is 8 clocks and the longest timeout (64 ticks) is about 520 clocks. This makes every rate select, the power-on and post-pulse restart timing, and the exact pulse width reachable within a short run. The measured timeout windows are checked against both the nominal lower bound and the one-tick upper bound.

// File: rtl/key_wdt_pkg.sv
package key_wdt_pkg;
  localparam logic [7:0] KEY_ARM   = 8'h55;
  localparam logic [7:0] KEY_FIRE  = 8'hAA;
  localparam int unsigned RATE_W    = 2;
  localparam int unsigned MAX_SHIFT = 2 * ((1 << RATE_W) - 1);
  localparam int unsigned TCNT_W    = MAX_SHIFT + 1;
  localparam int unsigned PULSE_LEN = 4;
  localparam int unsigned PULSE_W   = $clog2(PULSE_LEN + 1);
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PRESC_W = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  logic [PRESC_W-1:0] cnt_q;

  assign tick_o = !clr_i && (cnt_q == {PRESC_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (PRESC_W > 1) begin : g_tick_chk
      AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R4
    end
  endgenerate
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import key_wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic       svc_o
);
  logic armed_q;

  assign svc_o = we_i && (wdata_i == KEY_FIRE) && armed_q && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         armed_q <= 1'b0;
    else if (clr_i)                      armed_q <= 1'b0;
    else if (we_i && wdata_i == KEY_ARM)  armed_q <= 1'b1;
    else if (we_i && wdata_i == KEY_FIRE) armed_q <= 1'b0;
  end

  AST_FIRE_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i == KEY_FIRE && !armed_q) |=> !armed_q); // R3
  AST_ARM_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !clr_i && !(we_i && (wdata_i == KEY_FIRE))) |=> armed_q); // R2
endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout
  import key_wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              svc_i,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              expire_o
);
  logic [TCNT_W-1:0] tcnt_q;
  logic [TCNT_W-1:0] limit;

  // nominal count is N ticks; firing on the (N+1)th keeps the timeout >= nominal
  assign limit    = {{(TCNT_W-1){1'b0}}, 1'b1} << {rate_i, 1'b0};
  assign expire_o = tick_i && !svc_i && (tcnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tcnt_q <= '0;
    else if (clr_i || svc_i)  tcnt_q <= '0;
    else if (tick_i)          tcnt_q <= tcnt_q + 1'b1;
  end

  AST_SVC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_i |=> (tcnt_q == '0)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tcnt_q <= TCNT_W'((1 << MAX_SHIFT) + 1)); // R4
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse
  import key_wdt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  logic [PULSE_W-1:0] cnt_q;

  assign active_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (start_i)  cnt_q <= PULSE_W'(PULSE_LEN);
    else if (active_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/key_wdt.sv
module key_wdt
  import key_wdt_pkg::*;
#(
  parameter int unsigned PRESC_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  input  logic              wdt_en_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  output logic              sys_rst_no
);
  logic clr, tick, svc, expire, pulse_act;

  // disabled or self-reset: everything held cleared
  assign clr = !wdt_en_i || pulse_act;

  wdt_prescaler #(.PRESC_W(PRESC_W)) i_presc (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr), .tick_o(tick)
  );

  wdt_key_seq i_key (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .we_i(wr_en_i), .wdata_i(wr_data_i), .svc_o(svc)
  );

  wdt_timeout i_tmo (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .svc_i(svc),
    .tick_i(tick), .rate_i(rate_sel_i), .expire_o(expire)
  );

  wdt_pulse i_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(expire), .active_o(pulse_act)
  );

  assign sys_rst_no = !pulse_act;

  AST_PULSE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> (!$past(sys_rst_no, 4) && $past(sys_rst_no, 5))); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_en_i |=> !$fell(sys_rst_no)); // R6
endmodule

// File: tb/test_key_wdt.sv
module test_key_wdt;
  localparam int PW = 3;
  localparam int P  = 1 << PW;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       wdt_en_i = 1'b1;
  logic [1:0] rate_sel_i = 2'b00;
  logic       sys_rst_no;

  int total = 0;
  int bad   = 0;

  always #2 clk_i = ~clk_i;

  key_wdt #(.PRESC_W(PW)) i_key_wdt (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .wdt_en_i(wdt_en_i), .rate_sel_i(rate_sel_i), .sys_rst_no(sys_rst_no)
  );

  // {rate[1:0], noise between keys}
  localparam logic [2:0] VEC [8] = '{
    3'b00_0, 3'b01_0, 3'b10_0, 3'b11_0,
    3'b00_1, 3'b01_1, 3'b10_1, 3'b11_1
  };

  task automatic chk(input bit ok, input string req, input int act, input int lo, input int hi);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=[%0d..%0d]", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0; wr_data_i = 8'h00;
  endtask

  // edges until sys_rst_no low
  task automatic time_to_low(output int n);
    n = 0;
    do begin
      @(posedge clk_i); n++; #1;
    end while (sys_rst_no && n < 3000);
  endtask

  task automatic low_width(output int n);
    n = 0;
    while (!sys_rst_no && n < 100) begin
      @(posedge clk_i); n++; #1;
    end
  endtask

  task automatic restart(input logic [1:0] r);
    @(negedge clk_i); wdt_en_i = 1'b0; rate_sel_i = r;
    repeat (2) @(negedge clk_i);
    wdt_en_i = 1'b1;
  endtask

  function automatic int nt(input logic [1:0] r);
    return 1 << (2 * r);
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, w, lo, hi, lows;
    // R7: reset state
    repeat (3) @(negedge clk_i);
    chk(sys_rst_no === 1'b1, "R7 reset state", int'(sys_rst_no), 1, 1);
    @(negedge clk_i); rst_ni = 1'b1;
    time_to_low(n);
    chk(n >= P + 1 && n <= 2 * P + 1, "R7 first timeout", n, P + 1, 2 * P + 1);
    low_width(w);
    chk(w == 4, "R5 pulse width", w, 4, 4);

    // table: R4 window and R5 width per rate, R2 with noise writes
    for (int i = 0; i < 8; i++) begin
      logic [1:0] r;
      r = VEC[i][2:1];
      restart(r);
      wr(8'h55);
      if (VEC[i][0]) begin
        wr(8'h00); wr(8'h3C);
        repeat (3) @(negedge clk_i);
        wr(8'h55);
      end
      wr(8'hAA);
      time_to_low(n);
      lo = nt(r) * P + 1; hi = (nt(r) + 1) * P;
      chk(n >= lo && n <= hi, VEC[i][0] ? "R2 noise then fire" : "R4 timeout window", n, lo, hi);
      low_width(w);
      chk(w == 4, "R5 pulse width", w, 4, 4);
    end

    // R8: restart after own pulse, rate 01
    restart(2'b01);
    time_to_low(n);
    low_width(w);
    time_to_low(n);
    chk(n == 5 * P, "R8 restart after pulse", n, 5 * P, 5 * P);
    low_width(w);

    // R1: regular servicing keeps reset off
    restart(2'b01);
    lows = 0;
    for (int k = 0; k < 40; k++) begin
      wr(8'h55); wr(8'hAA);
      repeat (8) begin @(negedge clk_i); if (!sys_rst_no) lows++; end
    end
    chk(lows == 0, "R1 serviced stays high", lows, 0, 0);

    // R3: lone 0xAA does not service
    restart(2'b01);
    wr(8'h55); wr(8'hAA);
    repeat (20) @(negedge clk_i);
    wr(8'hAA);
    time_to_low(n);
    chk(n <= 5 * P - 21, "R3 lone fire ignored", n, 1, 5 * P - 21);
    low_width(w);

    // R3: second 0xAA after a completed sequence also ignored
    restart(2'b01);
    wr(8'h55); wr(8'hAA);
    repeat (20) @(negedge clk_i);
    wr(8'h12); wr(8'hAA);
    time_to_low(n);
    chk(n <= 5 * P - 23, "R3 fire after disarm", n, 1, 5 * P - 23);
    low_width(w);

    // R6: disabled stays quiet
    @(negedge clk_i); wdt_en_i = 1'b0; rate_sel_i = 2'b00;
    lows = 0;
    repeat (600) begin @(negedge clk_i); if (!sys_rst_no) lows++; end
    chk(lows == 0, "R6 disabled quiet", lows, 0, 0);
    wdt_en_i = 1'b1;
    time_to_low(n);
    chk(n >= P + 1 && n <= 2 * P + 1, "R6 cleared while disabled", n, P + 1, 2 * P + 1);
    low_width(w);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule